// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the instruction fetch address for a small 8-bit RISC core whose program space is 1K words of 13-bit instructions. It holds a 10-bit program counter, a two-bit high-address buffer, and a five-entry circular return stack. Each cycle the decoder raises zero or more control strobes. The sequencer picks the winner by a fixed priority and then steps, jumps, calls, returns, vectors to an interrupt, or loads the counter from a data-bus write to the PC-low register.

Every non-sequential load raises a flush flag. This flag is visible in the same cycle as the new address, so the fetch stage can discard the instruction already fetched. Calls push the address after the call. Interrupt entry pushes the address that was about to execute. Returns pop the newest entry. The stack never reports overflow or underflow. It wraps around instead.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, fetch_addr_o is 3FFh, pcl_o is FFh and flush_o is 0. All return-stack entries and the high buffer are cleared to zero, so a pop before any push yields 000h.
- R2: When only next_i is high, the address after the clock edge is the old address plus one, and 3FFh wraps to 000h. When no strobe is high, the address holds.
- R3: jump_i loads the full 10-bit target_i with no paging.
- R4: call_i loads target_i and pushes the old address plus one (wrapping) onto the return stack.
- R5: ret_i loads the address pushed most recently and not yet popped.
- R6: hw_irq_i loads 008h and sw_irq_i loads 002h. Both push the current address unchanged.
- R7: When several strobes are high together, only one is acted on. The priority from highest to lowest is hw_irq_i, sw_irq_i, ret_i, call_i, jump_i, pcl_wr_i, next_i.
- R8: hibuf_wr_i stores data_i[1:0] into the high buffer. pcl_wr_i loads the counter with {high buffer, data_i[7:0]}. When both are high in the same cycle, the counter uses the buffer value from before the write.
- R9: pcl_o always equals fetch_addr_o[7:0].
- R10: The stack holds five entries and wraps. A sixth push overwrites the oldest entry. Further pops keep cycling through the five slots, newest first.
- R11: flush_o is high exactly in the cycles whose fetch_addr_o came from a jump, call, return, interrupt or PC-low write. It is low after a sequential step or a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| next_i | input | 1 | Sequential step strobe |
| jump_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| hw_irq_i | input | 1 | Hardware interrupt entry strobe |
| sw_irq_i | input | 1 | Software interrupt entry strobe |
| pcl_wr_i | input | 1 | Data write to the PC-low register |
| hibuf_wr_i | input | 1 | Data write to the high-address buffer |
| target_i | input | 10 | Jump or call target |
| data_i | input | 8 | Data byte for PC-low or high-buffer writes |
| fetch_addr_o | output | 10 | Current fetch address |
| pcl_o | output | 8 | PC-low readback |
| flush_o | output | 1 | Discard the instruction fetched before this address |

## Verification
The in-RTL assertions watch the following on every cycle:
- sequential stepping and holding;
- jumps that nothing outranks;
- both interrupt vectors;
- a return loading the popped entry;
- flush_o appearing only after a load;
- the stack pointer staying in range, with no simultaneous push and pop.

The following can only be shown by the bench scenarios, which compare against a separate model:
- the contents of the return stack across deep call chains, including the overwrite after five pushes and the wrap on extra pops;
- the merge of the high buffer into PC-low writes, including the write in the same cycle;
- the complete priority ladder;
- the cleared stack seen by a pop straight after reset.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_NEXT,
    OP_PCLW,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_SWI,
    OP_HWI
  } pc_op_e;
endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
  import pcs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   next_i,
  input  logic   jump_i,
  input  logic   call_i,
  input  logic   ret_i,
  input  logic   hw_irq_i,
  input  logic   sw_irq_i,
  input  logic   pcl_wr_i,
  output pc_op_e op_o
);
  logic [6:0] req;
  logic [6:0] gnt;

  // index 6 is highest priority
  assign req = {hw_irq_i, sw_irq_i, ret_i, call_i, jump_i, pcl_wr_i, next_i};

  always_comb begin
    gnt = '0;
    for (int i = 6; i >= 0; i--) begin
      if (req[i] && gnt == '0) gnt[i] = 1'b1;
    end
  end

  always_comb begin
    unique case (1'b1)
      gnt[6]:  op_o = OP_HWI;
      gnt[5]:  op_o = OP_SWI;
      gnt[4]:  op_o = OP_RET;
      gnt[3]:  op_o = OP_CALL;
      gnt[2]:  op_o = OP_JUMP;
      gnt[1]:  op_o = OP_PCLW;
      gnt[0]:  op_o = OP_NEXT;
      default: op_o = OP_HOLD;
    endcase
  end

  AST_ONE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && ((req != '0) == (gnt != '0))) else $error("grant"); // R7
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int DEPTH = 5,
  parameter int W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] tos_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec;
  logic [W-1:0]     slot_q [DEPTH];

  assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
  assign tos_o   = slot_q[ptr_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_inc;
    else if (pop_i)  ptr_q <= ptr_dec;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (push_i && ptr_q == PTR_W'(g)) slot_q[g] <= wdata_i;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST) else $error("ptr range"); // R10
  AST_NO_PUSH_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)) else $error("push+pop"); // R7
  AST_PUSH_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> tos_o == $past(wdata_i)) else $error("push"); // R4
endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
#(
  parameter int              PC_W   = 10,
  parameter int              DATA_W = 8,
  parameter logic [PC_W-1:0] HW_VEC = 10'h008,
  parameter logic [PC_W-1:0] SW_VEC = 10'h002
) (
  input  pc_op_e                  op_i,
  input  logic [PC_W-1:0]         pc_i,
  input  logic [PC_W-1:0]         target_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic [PC_W-DATA_W-1:0]  hibuf_i,
  input  logic [PC_W-1:0]         tos_i,
  output logic [PC_W-1:0]         pc_d_o,
  output logic                    push_o,
  output logic                    pop_o,
  output logic [PC_W-1:0]         push_data_o,
  output logic                    load_o
);
  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc_i + 1'b1;

  always_comb begin
    pc_d_o      = pc_i;
    push_o      = 1'b0;
    pop_o       = 1'b0;
    push_data_o = pc_i;
    load_o      = 1'b1;
    unique case (op_i)
      OP_HWI:  begin pc_d_o = HW_VEC; push_o = 1'b1; end
      OP_SWI:  begin pc_d_o = SW_VEC; push_o = 1'b1; end
      OP_RET:  begin pc_d_o = tos_i;  pop_o  = 1'b1; end
      OP_CALL: begin pc_d_o = target_i; push_o = 1'b1; push_data_o = pc_inc; end
      OP_JUMP: pc_d_o = target_i;
      OP_PCLW: pc_d_o = {hibuf_i, data_i};
      OP_NEXT: begin pc_d_o = pc_inc; load_o = 1'b0; end
      default: load_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int              PC_W      = 10,
  parameter int              DATA_W    = 8,
  parameter int              DEPTH     = 5,
  parameter logic [PC_W-1:0] RESET_VEC = 10'h3FF,
  parameter logic [PC_W-1:0] HW_VEC    = 10'h008,
  parameter logic [PC_W-1:0] SW_VEC    = 10'h002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              next_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              hw_irq_i,
  input  logic              sw_irq_i,
  input  logic              pcl_wr_i,
  input  logic              hibuf_wr_i,
  input  logic [9:0]        target_i,
  input  logic [7:0]        data_i,
  output logic [9:0]        fetch_addr_o,
  output logic [7:0]        pcl_o,
  output logic              flush_o
);
  localparam int HI_W = PC_W - DATA_W;

  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_d, tos, push_data;
  logic [HI_W-1:0] hibuf_q;
  logic            push, pop, load, flush_q;

  pcs_arbiter u_arb (
    .clk_i, .rst_ni, .next_i, .jump_i, .call_i, .ret_i,
    .hw_irq_i, .sw_irq_i, .pcl_wr_i, .op_o(op)
  );

  pcs_next_pc #(.PC_W(PC_W), .DATA_W(DATA_W), .HW_VEC(HW_VEC), .SW_VEC(SW_VEC)) u_npc (
    .op_i(op), .pc_i(pc_q), .target_i(target_i), .data_i(data_i),
    .hibuf_i(hibuf_q), .tos_i(tos), .pc_d_o(pc_d), .push_o(push),
    .pop_o(pop), .push_data_o(push_data), .load_o(load)
  );

  pcs_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop),
    .wdata_i(push_data), .tos_o(tos)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_VEC;
      hibuf_q <= '0;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      flush_q <= load;
      if (hibuf_wr_i) hibuf_q <= data_i[HI_W-1:0];
    end
  end

  assign fetch_addr_o = pc_q;
  assign pcl_o        = pc_q[DATA_W-1:0];
  assign flush_o      = flush_q;

  logic any_load, above_jump;
  assign above_jump = hw_irq_i | sw_irq_i | ret_i | call_i;
  assign any_load   = above_jump | jump_i | pcl_wr_i;

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_i && !any_load) |=> fetch_addr_o == 10'($past(fetch_addr_o) + 1'b1)) else $error("step"); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!next_i && !any_load) |=> $stable(fetch_addr_o)) else $error("hold"); // R2
  AST_JUMP_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !above_jump) |=> fetch_addr_o == $past(target_i)) else $error("jump"); // R3
  AST_HW_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_irq_i |=> fetch_addr_o == HW_VEC) else $error("hw vec"); // R6
  AST_SW_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_irq_i && !hw_irq_i) |=> fetch_addr_o == SW_VEC) else $error("sw vec"); // R6
  AST_RET_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !hw_irq_i && !sw_irq_i) |=> fetch_addr_o == $past(tos)) else $error("ret"); // R5
  AST_FLUSH_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(any_load)) else $error("flush"); // R11
endmodule

// File: tb/pc_sequencer_tb.sv
`timescale 1ns/1ps
module pc_sequencer_tb;
  localparam logic [6:0] S_HW = 7'b1000000, S_SW = 7'b0100000, S_RET = 7'b0010000,
                         S_CALL = 7'b0001000, S_JMP = 7'b0000100, S_PCLW = 7'b0000010,
                         S_NXT = 7'b0000001, S_NONE = 7'b0000000;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       next_i = 0, jump_i = 0, call_i = 0, ret_i = 0, hw_irq_i = 0, sw_irq_i = 0;
  logic       pcl_wr_i = 0, hibuf_wr_i = 0;
  logic [9:0] target_i = '0;
  logic [7:0] data_i = '0;
  logic [9:0] fetch_addr_o;
  logic [7:0] pcl_o;
  logic       flush_o;

  int checks = 0, failures = 0, cycles = 0;
  bit reported = 0;

  logic [9:0] m_pc = 10'h3FF;
  logic [1:0] m_hb = '0;
  logic [9:0] m_stk [5];
  int         m_sp = 0;

  logic [9:0] q_addr [$];
  logic       q_fl [$];
  string      q_tag [$];

  always #2.5 clk = ~clk;

  pc_sequencer u_dut (
    .clk_i(clk), .rst_ni, .next_i, .jump_i, .call_i, .ret_i, .hw_irq_i, .sw_irq_i,
    .pcl_wr_i, .hibuf_wr_i, .target_i, .data_i, .fetch_addr_o, .pcl_o, .flush_o
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_push(logic [9:0] v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 5;
  endtask

  task automatic drive(string tag, logic [6:0] s, logic hbw = 0,
                       logic [9:0] tgt = '0, logic [7:0] dat = '0);
    logic fl;
    @(negedge clk);
    {hw_irq_i, sw_irq_i, ret_i, call_i, jump_i, pcl_wr_i, next_i} = s;
    hibuf_wr_i = hbw; target_i = tgt; data_i = dat;
    fl = 1'b1;
    if (s[6])      begin m_push(m_pc); m_pc = 10'h008; end
    else if (s[5]) begin m_push(m_pc); m_pc = 10'h002; end
    else if (s[4]) begin m_sp = (m_sp + 4) % 5; m_pc = m_stk[m_sp]; end
    else if (s[3]) begin m_push(m_pc + 10'd1); m_pc = tgt; end
    else if (s[2]) m_pc = tgt;
    else if (s[1]) m_pc = {m_hb, dat};
    else if (s[0]) begin m_pc = m_pc + 10'd1; fl = 1'b0; end
    else fl = 1'b0;
    if (hbw) m_hb = dat[1:0];
    q_addr.push_back(m_pc);
    q_fl.push_back(fl);
    q_tag.push_back(tag);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      string t;
      logic [9:0] ea;
      logic ef;
      t = q_tag.pop_front(); ea = q_addr.pop_front(); ef = q_fl.pop_front();
      check(t, 32'(fetch_addr_o), 32'(ea));
      check({t, "/R11 flush"}, 32'(flush_o), 32'(ef));
      check("R9 pcl", 32'(pcl_o), 32'(fetch_addr_o[7:0]));
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      report();
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 addr in reset", 32'(fetch_addr_o), 32'h3FF);
    rst_ni = 1'b1;
    #0.5;
    check("R1 addr", 32'(fetch_addr_o), 32'h3FF);
    check("R1 pcl", 32'(pcl_o), 32'hFF);
    check("R1 flush", 32'(flush_o), 32'h0);

    drive("R1 empty pop", S_RET);
    drive("R2 step", S_NXT);
    drive("R2 hold", S_NONE);
    drive("R3 jump", S_JMP, 0, 10'h3FE);
    drive("R2 step", S_NXT);
    drive("R2 wrap", S_NXT);
    drive("R4 call", S_CALL, 0, 10'h155);
    drive("R2 step", S_NXT);
    drive("R5 ret", S_RET);
    drive("R6 hw irq", S_HW);
    drive("R6 sw irq", S_SW);
    drive("R5 ret sw", S_RET);
    drive("R5 ret hw", S_RET);
    drive("R7 hw>sw>jump", S_HW | S_SW | S_JMP, 0, 10'h0AA);
    drive("R7 sw>ret>call", S_SW | S_RET | S_CALL, 0, 10'h0BB);
    drive("R7 ret>call>jump", S_RET | S_CALL | S_JMP, 0, 10'h0CC);
    drive("R7 call>jump", S_CALL | S_JMP, 0, 10'h2DD, 8'h11);
    drive("R7 jump>pclw", S_JMP | S_PCLW, 0, 10'h1EE, 8'h22);
    drive("R7 pclw>next", S_PCLW | S_NXT, 0, 10'h000, 8'h33);
    drive("R8 hibuf write", S_NONE, 1, 10'h000, 8'hFE);
    drive("R8 pcl merge", S_PCLW, 0, 10'h000, 8'h34);
    drive("R8 same-cycle old buf", S_PCLW, 1, 10'h000, 8'h55);
    drive("R8 new buf", S_PCLW, 0, 10'h000, 8'h00);
    for (int i = 0; i < 6; i++) drive("R10 deep call", S_CALL, 0, 10'(10'h040 + i*10'h21));
    for (int i = 0; i < 7; i++) drive("R10 deep ret", S_RET);
    drive("R2 step", S_NXT);
    drive("R2 hold", S_NONE);
    @(negedge clk);
    {hw_irq_i, sw_irq_i, ret_i, call_i, jump_i, pcl_wr_i, next_i} = S_NONE;
    hibuf_wr_i = 0;
    repeat (3) @(negedge clk);
    check("queue drained", 32'(q_tag.size()), 32'd0);
    report();
  end
endmodule